// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block turns words offered on a valid/ready input into asynchronous serial frames on a single output line. Each frame has a low start bit, five to nine data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The line rests high between frames. Bit timing comes from a one-cycle baud-tick pulse supplied from outside, and every bit on the line lasts exactly one tick period.

Two independent conditions hold back new frames. The first is a hardware clear-to-send input. The second is a software pause state, which a neighbouring receiver sets and clears by reporting decoded characters. The pause character is 0x13 and the resume character is 0x11. A frame that has already been accepted always runs to its last stop bit, whatever happens to either condition while it is on the line. A new word is taken only when the transmitter is idle, clear-to-send is high and the pause state is clear.

Top module: `uart_fc_tx`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with the pause state cleared and `txd` high. After reset, with `cts` high, `in_ready` is 1.
- R2: A frame begins at the first `baud_tick` after acceptance with `txd` low for one tick period. Every later bit also lasts exactly one tick period. `txd` changes only in the cycle after a `baud_tick`.
- R3: The 4-bit field `cfg_data_bits` gives the data bit count. Values below 5 act as 5 and values above 9 act as 9. Data bits go out LSB first from `in_data[0]` upward, and bits of `in_data` above the count are never sent.
- R4: When `cfg_parity_en` is 1, one parity bit follows the last data bit. It is the XOR of the configured data bits only, inverted when `cfg_parity_odd` is 1. When `cfg_parity_en` is 0, no parity bit is sent.
- R5: One stop bit follows when `cfg_two_stop` is 0 and two when it is 1, both driven high. The block returns to idle after the last stop bit.
- R6: A word is accepted on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when the block is idle, not paused and `cts` is 1. The configuration is captured at acceptance, so later changes do not alter that frame.
- R7: While `cts` is 0 no new frame starts and `in_ready` is 0. A frame already accepted completes unchanged if `cts` falls during it.
- R8: A reported character 0x13 (`rx_char_valid` high) sets the pause state, and 0x11 clears it. Any other character leaves the state unchanged.
- R9: A pause that arrives during a frame lets that frame finish and blocks the next one. Sending resumes only when the pause is cleared and `cts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_data_bits | input | 4 | Data bit count, clamped to 5..9 |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cts | input | 1 | Clear-to-send, high permits a new frame |
| rx_char_valid | input | 1 | Decoded character strobe from the receive path |
| rx_char | input | 8 | Decoded character value |
| in_valid | input | 1 | Word offered |
| in_data | input | 9 | Word to send, LSB first |
| in_ready | output | 1 | Word can be accepted this cycle |
| txd | output | 1 | Serial line, idles high |

## Verification
The hardest conditions to reach are the ones where flow control changes while a frame is on the line. These are a pause character or a falling `cts` between the start and the stop bits, and a configuration change just after acceptance. The bench reaches them by driving the disturbance at a fixed point right after it has sampled the start bit. It then checks every later bit against the captured settings, and checks at the return to idle that `in_ready` stays low until both holds are gone. A table of frame shapes covers the widths, parities and stop counts, including data with bits set above the configured width.

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
  parameter int          MIN_BITS    = 5,
  parameter int          MAX_BITS    = 9,
  parameter logic [7:0]  PAUSE_CODE  = 8'h13,
  parameter logic [7:0]  RESUME_CODE = 8'h11,
  localparam int         NW          = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic [NW-1:0]       cfg_data_bits,
  input  logic                cfg_parity_en,
  input  logic                cfg_parity_odd,
  input  logic                cfg_two_stop,
  input  logic                cts,
  input  logic                rx_char_valid,
  input  logic [7:0]          rx_char,
  input  logic                in_valid,
  input  logic [MAX_BITS-1:0] in_data,
  output logic                in_ready,
  output logic                txd
);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                 st;
  logic [MAX_BITS-1:0] sh;
  logic [NW-1:0]       nb, bcnt, nb_in;
  logic                pen, par, two, stop2nd, paused;
  logic [MAX_BITS-1:0] mask;
  logic                par_in, accept;

  assign nb_in = (cfg_data_bits < NW'(MIN_BITS)) ? NW'(MIN_BITS) :
                 (cfg_data_bits > NW'(MAX_BITS)) ? NW'(MAX_BITS) : cfg_data_bits;

  always_comb begin
    mask = '0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(nb_in)) mask[i] = 1'b1;
  end

  assign par_in   = ^(in_data & mask) ^ cfg_parity_odd;
  assign in_ready = (st == S_IDLE) && !paused && cts;
  assign accept   = in_valid && in_ready;

  assign txd = (st == S_START) ? 1'b0 :
               (st == S_DATA)  ? sh[0] :
               (st == S_PAR)   ? par : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      paused  <= 1'b0;
      sh      <= '0;
      nb      <= NW'(MIN_BITS);
      bcnt    <= '0;
      pen     <= 1'b0;
      par     <= 1'b0;
      two     <= 1'b0;
      stop2nd <= 1'b0;
    end else begin
      if (rx_char_valid) begin
        if (rx_char == PAUSE_CODE)       paused <= 1'b1;
        else if (rx_char == RESUME_CODE) paused <= 1'b0;
      end
      case (st)
        S_IDLE: if (accept) begin
          sh  <= in_data;
          nb  <= nb_in;
          pen <= cfg_parity_en;
          par <= par_in;
          two <= cfg_two_stop;
          st  <= S_ARM;
        end
        S_ARM: if (baud_tick) st <= S_START;
        S_START: if (baud_tick) begin
          st   <= S_DATA;
          bcnt <= '0;
        end
        S_DATA: if (baud_tick) begin
          sh <= sh >> 1;
          if (bcnt == nb - 1'b1) begin
            st      <= pen ? S_PAR : S_STOP;
            stop2nd <= 1'b0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_PAR: if (baud_tick) begin
          st      <= S_STOP;
          stop2nd <= 1'b0;
        end
        S_STOP: if (baud_tick) begin
          if (two && !stop2nd) stop2nd <= 1'b1;
          else                 st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(txd));

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARM && baud_tick) |=> !txd);

  p_cts_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!cts && st == S_IDLE) |=> st == S_IDLE);

  p_pause_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_char_valid && rx_char == PAUSE_CODE) |=> !in_ready);

  p_resume_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_char_valid && rx_char == RESUME_CODE && st == S_IDLE && !in_valid)
      |=> (in_ready || !cts));

endmodule

// File: tb/uart_fc_tx_test.sv
`timescale 1ns/1ps
module uart_fc_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [3:0] cfg_data_bits = 4'd8;
  logic       cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       cts = 1'b1;
  logic       rx_char_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready, txd;

  int total = 0, fails = 0, cyc = 0, tdiv = 0;
  bit done = 0;

  uart_fc_tx uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
    .cts(cts), .rx_char_valid(rx_char_valid), .rx_char(rx_char),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == 7) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 7);
  end

  // {bits[15:12], parity_en[11], parity_odd[10], two_stop[9], data[8:0]}
  localparam logic [15:0] VEC [0:7] = '{
    {4'd8, 1'b0, 1'b0, 1'b0, 9'h0A5},
    {4'd7, 1'b1, 1'b0, 1'b0, 9'h0D3},
    {4'd7, 1'b1, 1'b1, 1'b0, 9'h0D3},
    {4'd5, 1'b0, 1'b0, 1'b1, 9'h1F6},
    {4'd9, 1'b1, 1'b0, 1'b1, 9'h1C3},
    {4'd6, 1'b1, 1'b1, 1'b0, 9'h02D},
    {4'd8, 1'b1, 1'b0, 1'b1, 9'h0FF},
    {4'd9, 1'b0, 1'b0, 1'b0, 9'h100}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    rx_char = c; rx_char_valid = 1'b1;
    @(negedge clk);
    rx_char_valid = 1'b0;
  endtask

  function automatic int clampn(input logic [3:0] n);
    if (n < 5) return 5;
    if (n > 9) return 9;
    return int'(n);
  endfunction

  // act: 0 plain, 1 drop cts after start, 2 pause after start, 3 change config after accept
  task automatic run_frame(input logic [15:0] v, input int act);
    int n;
    logic pe, po, ts, p;
    n  = clampn(v[15:12]);
    pe = v[11]; po = v[10]; ts = v[9];
    cfg_data_bits = v[15:12]; cfg_parity_en = pe; cfg_parity_odd = po; cfg_two_stop = ts;
    while (!in_ready) @(negedge clk);
    in_data = v[8:0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_data = ~v[8:0];
    if (act == 3) begin
      cfg_data_bits = 4'd5; cfg_parity_en = ~pe; cfg_parity_odd = ~po; cfg_two_stop = ~ts;
    end
    chk(txd === 1'b1, "R6 armed line high", txd, 1);
    wait_tick();
    chk(txd === 1'b0, "R2 start bit", txd, 0);
    if (act == 1) cts = 1'b0;
    if (act == 2) send_char(8'h13);
    p = po;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      chk(txd === v[i], "R3 data bit", txd, v[i]);
      p ^= v[i];
    end
    if (pe) begin
      wait_tick();
      chk(txd === p, "R4 parity bit", txd, p);
    end
    wait_tick();
    chk(txd === 1'b1, "R5 stop bit 1", txd, 1);
    if (ts) begin
      wait_tick();
      chk(txd === 1'b1 && !in_ready, "R5 stop bit 2", {txd, in_ready}, 2'b10);
    end
    wait_tick();
    chk(txd === 1'b1, "R5 idle after stop", txd, 1);
    chk(in_ready === (act == 0 || act == 3), "R7 R9 ready after frame", in_ready, (act == 0 || act == 3));
    if (act == 1) begin
      cts = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R7 ready when cts returns", in_ready, 1);
    end
    if (act == 2) begin
      cts = 1'b0;
      send_char(8'h11);
      chk(in_ready === 1'b0, "R9 resume without cts", in_ready, 0);
      cts = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R9 resume with cts", in_ready, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b1, "R1 reset state", {txd, in_ready}, 2'b11);

    for (int k = 0; k < 8; k++) run_frame(VEC[k], 0);

    // R3 clamping of out-of-range widths
    run_frame({4'd3, 1'b1, 1'b0, 1'b0, 9'h1FF}, 0);
    run_frame({4'd15, 1'b1, 1'b1, 1'b0, 9'h155}, 0);

    // R7 cts low holds off a waiting word
    cts = 1'b0;
    in_data = 9'h055; in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R7 ready low without cts", in_ready, 0);
    for (int t = 0; t < 3; t++) begin
      wait_tick();
      chk(txd === 1'b1, "R7 no start without cts", txd, 1);
    end
    in_valid = 1'b0;
    cts = 1'b1;
    run_frame(VEC[1], 1);

    // R8 pause, ignored characters, resume
    send_char(8'h41);
    chk(in_ready === 1'b1, "R8 other char ignored while running", in_ready, 1);
    send_char(8'h13);
    chk(in_ready === 1'b0, "R8 pause char", in_ready, 0);
    send_char(8'h41);
    chk(in_ready === 1'b0, "R8 other char ignored while paused", in_ready, 0);
    in_valid = 1'b1; in_data = 9'h0F0;
    wait_tick(); wait_tick();
    chk(txd === 1'b1, "R8 no frame while paused", txd, 1);
    in_valid = 1'b0;
    send_char(8'h11);
    chk(in_ready === 1'b1, "R8 resume char", in_ready, 1);

    // R9 pause during a frame
    run_frame(VEC[4], 2);

    // R6 configuration captured at acceptance
    run_frame(VEC[2], 3);

    // R1 reset during a frame clears line and pause
    cfg_data_bits = 4'd8; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
    in_data = 9'h000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_tick(); wait_tick();
    send_char(8'h13);
    chk(txd === 1'b0, "R2 low data bit before reset", txd, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b1, "R1 reset mid frame", {txd, in_ready}, 2'b11);
    run_frame(VEC[0], 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule